// File: doc/BRIEF.md
# Full-Duplex Synchronous Serial Master with Clock Stall

This block is a synchronous serial master that generates its own shift clock and exchanges one 8-bit frame in each direction at once. Each bit goes out on the data output while a bit comes in on the data input. A processor-side port writes bytes into a transmit buffer and reads bytes from a receive buffer. Two flags report when the transmit buffer is empty and when the receive buffer holds a byte. Two single-cycle pulses mark the end of a transmission and the arrival of a received byte.

The shift clock only runs when a full exchange can take place. It does not start until a byte has been written. It pauses at a frame boundary when there is nothing to send or nowhere to put the incoming byte. Once the processor has both read and written, in either order, the clock resumes without any further action.

A mode input selects single or double buffering. Change it only while the engine is idle and both buffers are empty. In single mode the transmit buffer stays occupied until its frame ends. In double mode the byte moves into the shift register when its frame starts, so the next byte can be written during the frame. A one-byte receive hold stage in this mode also absorbs one extra frame.

Top module: `duplex_sync_master`

## Requirements
- R1: After a synchronous active-low reset, `sclk` and `sdo` are high, `tx_empty` is 1, `rx_full` is 0, and both interrupt pulses are low.
- R2: `sclk` stays high while the engine is idle. A frame begins only after a byte has been written into the transmit buffer and the receive side has room.
- R3: A frame is 8 bits, least significant bit first. `sdo` changes on the falling edge of `sclk` and `sdi` is sampled on the rising edge. The low and high phases of `sclk` each last CLK_DIV system clocks.
- R4: In single mode (`dbl_mode`=0), at the end of a frame the received byte is placed in the receive buffer and `rx_full` and `tx_empty` are set. `tx_irq` and `rx_irq` pulse in the same cycle.
- R5: In single mode the next frame starts only after the receive buffer has been read and a new byte has been written. Either order works, and `sclk` stays high until both have happened.
- R6: A write (`tx_wr`) is accepted only when `tx_empty` is 1; otherwise it is ignored. In single mode this also applies during a running frame.
- R7: In double mode (`dbl_mode`=1), `tx_empty` returns to 1 as soon as a frame starts. A byte written during that frame is sent in the next frame with no pause.
- R8: In double mode, a frame that ends while the receive buffer is full leaves its byte in a hold stage and raises no `rx_irq`. `sclk` then stops at the frame boundary. After a read, the held byte moves into the buffer with an `rx_irq` pulse, and the clock resumes.
- R9: Once a frame has started it always runs to the end; a stall happens only between frames.
- R10: `tx_irq` and `rx_irq` are single-cycle pulses. Each frame produces exactly one `tx_irq`, and each byte that enters the receive buffer produces exactly one `rx_irq`.
- R11: A read (`rx_rd`) while `rx_full` is 1 clears `rx_full` in the next cycle. Received bytes reach the processor in arrival order, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dbl_mode | input | 1 | 0 = single buffering, 1 = double buffering |
| tx_wr | input | 1 | Transmit-buffer write strobe |
| tx_wdata | input | FRAME_BITS | Byte to transmit |
| rx_rd | input | 1 | Receive-buffer read strobe |
| rx_rdata | output | FRAME_BITS | Receive-buffer contents |
| tx_empty | output | 1 | Transmit buffer can accept a byte |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| tx_irq | output | 1 | Pulse: a frame finished sending |
| rx_irq | output | 1 | Pulse: a byte entered the receive buffer |
| sclk | output | 1 | Serial shift clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The critical overlap is a frame ending in the same cycle as a processor read of the receive buffer. In double mode the buffer still counts as full in that cycle, so the new byte must go through the hold stage and arrive two cycles later rather than being dropped or overwriting. The random phases issue reads and writes on arbitrary cycles while frames run back to back, so such collisions occur many times. A scoreboard judges them by requiring every received byte in arrival order and every accepted transmit byte on the wire in write order. In single mode both interrupt pulses must also coincide at each frame end, which a directed test checks.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
   typedef enum logic {
      BUF_SINGLE = 1'b0,
      BUF_DOUBLE = 1'b1
   } buf_mode_e;
endpackage

// File: rtl/dsm_phase_gen.sv
module dsm_phase_gen #(
   parameter int CLK_DIV    = 4,
   parameter int FRAME_BITS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic sclk,
   output logic rise_ev,
   output logic fall_ev,
   output logic frame_done
);
   localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam int BW = $clog2(FRAME_BITS);

   logic          busy_q;
   logic          sclk_q;
   logic [CW-1:0] cnt_q;
   logic [BW-1:0] bit_q;
   logic          tick;
   logic          last;

   assign tick       = (cnt_q == CW'(CLK_DIV - 1));
   assign last       = (bit_q == BW'(FRAME_BITS - 1));
   assign rise_ev    = busy_q & tick & ~sclk_q;
   assign fall_ev    = busy_q & tick & sclk_q & ~last;
   assign frame_done = busy_q & tick & sclk_q & last;
   assign busy       = busy_q;
   assign sclk       = sclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b1;
         cnt_q  <= '0;
         bit_q  <= '0;
      end else if (start) begin
         busy_q <= 1'b1;
         sclk_q <= 1'b0;
         cnt_q  <= '0;
         bit_q  <= '0;
      end else if (busy_q) begin
         if (tick) begin
            cnt_q <= '0;
            if (!sclk_q) begin
               sclk_q <= 1'b1;
            end else if (last) begin
               busy_q <= 1'b0;
            end else begin
               sclk_q <= 1'b0;
               bit_q  <= bit_q + BW'(1);
            end
         end else begin
            cnt_q <= cnt_q + CW'(1);
         end
      end
   end
endmodule

// File: rtl/dsm_shifter.sv
module dsm_shifter #(
   parameter int W         = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_word,
   input  logic         rise_ev,
   input  logic         fall_ev,
   input  logic         sdi,
   output logic         sdo,
   output logic [W-1:0] rx_word
);
   logic [W-1:0] tx_sh;
   logic [W-1:0] rx_sh;
   logic         sdo_q;
   logic [W-1:0] tx_next;
   logic [W-1:0] rx_next;
   logic         load_bit;
   logic         next_bit;

   generate
      if (LSB_FIRST) begin : g_lsb
         assign tx_next  = {1'b0, tx_sh[W-1:1]};
         assign rx_next  = {sdi, rx_sh[W-1:1]};
         assign load_bit = load_word[0];
         assign next_bit = tx_sh[1];
      end else begin : g_msb
         assign tx_next  = {tx_sh[W-2:0], 1'b0};
         assign rx_next  = {rx_sh[W-2:0], sdi};
         assign load_bit = load_word[W-1];
         assign next_bit = tx_sh[W-2];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_sh <= '0;
         rx_sh <= '0;
         sdo_q <= 1'b1;
      end else begin
         if (load) begin
            tx_sh <= load_word;
            sdo_q <= load_bit;
         end else if (fall_ev) begin
            tx_sh <= tx_next;
            sdo_q <= next_bit;
         end
         if (rise_ev) rx_sh <= rx_next;
      end
   end

   assign sdo     = sdo_q;
   assign rx_word = rx_sh;
endmodule

// File: rtl/dsm_buf_ctrl.sv
module dsm_buf_ctrl
   import dsm_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dbl_mode,
   input  logic         tx_wr,
   input  logic [W-1:0] tx_wdata,
   input  logic         rx_rd,
   input  logic         busy,
   input  logic         frame_done,
   input  logic [W-1:0] rx_word,
   output logic         start,
   output logic [W-1:0] tx_word,
   output logic [W-1:0] rx_rdata,
   output logic         tx_empty,
   output logic         rx_full,
   output logic         tx_irq,
   output logic         rx_irq
);
   buf_mode_e    mode;
   logic [W-1:0] tx_buf;
   logic         tx_empty_q;
   logic [W-1:0] rx_buf;
   logic         rx_full_q;
   logic [W-1:0] hold_q;
   logic         hold_vld_q;
   logic         tx_irq_q;
   logic         rx_irq_q;
   logic         rx_room;
   logic         wr_ok;
   logic         rd_ok;
   logic         direct;
   logic         drain;

   assign mode    = buf_mode_e'(dbl_mode);
   assign rx_room = (mode == BUF_DOUBLE) ? ~hold_vld_q : (~rx_full_q & ~hold_vld_q);
   assign start   = ~busy & ~tx_empty_q & rx_room;
   assign wr_ok   = tx_wr & tx_empty_q;
   assign rd_ok   = rx_rd & rx_full_q;
   assign direct  = frame_done & ~rx_full_q;
   assign drain   = hold_vld_q & ~rx_full_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_buf     <= '0;
         tx_empty_q <= 1'b1;
         rx_buf     <= '0;
         rx_full_q  <= 1'b0;
         hold_q     <= '0;
         hold_vld_q <= 1'b0;
         tx_irq_q   <= 1'b0;
         rx_irq_q   <= 1'b0;
      end else begin
         tx_irq_q <= frame_done;
         rx_irq_q <= direct | drain;

         if (wr_ok) begin
            tx_buf     <= tx_wdata;
            tx_empty_q <= 1'b0;
         end else if (start && mode == BUF_DOUBLE) begin
            tx_empty_q <= 1'b1;
         end else if (frame_done && mode == BUF_SINGLE) begin
            tx_empty_q <= 1'b1;
         end

         if (rd_ok) begin
            rx_full_q <= 1'b0;
         end else if (direct) begin
            rx_buf    <= rx_word;
            rx_full_q <= 1'b1;
         end else if (drain) begin
            rx_buf    <= hold_q;
            rx_full_q <= 1'b1;
         end

         if (frame_done && rx_full_q) begin
            hold_q     <= rx_word;
            hold_vld_q <= 1'b1;
         end else if (drain) begin
            hold_vld_q <= 1'b0;
         end
      end
   end

   assign tx_word  = tx_buf;
   assign rx_rdata = rx_buf;
   assign tx_empty = tx_empty_q;
   assign rx_full  = rx_full_q;
   assign tx_irq   = tx_irq_q;
   assign rx_irq   = rx_irq_q;
endmodule

// File: rtl/duplex_sync_master.sv
module duplex_sync_master #(
   parameter int CLK_DIV    = 4,
   parameter int FRAME_BITS = 8,
   parameter bit LSB_FIRST  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  dbl_mode,
   input  logic                  tx_wr,
   input  logic [FRAME_BITS-1:0] tx_wdata,
   input  logic                  rx_rd,
   output logic [FRAME_BITS-1:0] rx_rdata,
   output logic                  tx_empty,
   output logic                  rx_full,
   output logic                  tx_irq,
   output logic                  rx_irq,
   output logic                  sclk,
   output logic                  sdo,
   input  logic                  sdi
);
   generate
      if (CLK_DIV < 1) begin : g_bad_div
         $error("CLK_DIV must be at least 1");
      end
      if (FRAME_BITS < 2) begin : g_bad_bits
         $error("FRAME_BITS must be at least 2");
      end
   endgenerate

   logic                  start;
   logic                  busy;
   logic                  rise_ev;
   logic                  fall_ev;
   logic                  frame_done;
   logic [FRAME_BITS-1:0] tx_word;
   logic [FRAME_BITS-1:0] rx_word;

   dsm_phase_gen #(.CLK_DIV(CLK_DIV), .FRAME_BITS(FRAME_BITS)) u_phase (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .sclk(sclk),
      .rise_ev(rise_ev), .fall_ev(fall_ev), .frame_done(frame_done)
   );

   dsm_shifter #(.W(FRAME_BITS), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(start), .load_word(tx_word),
      .rise_ev(rise_ev), .fall_ev(fall_ev), .sdi(sdi), .sdo(sdo),
      .rx_word(rx_word)
   );

   dsm_buf_ctrl #(.W(FRAME_BITS)) u_buf (
      .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .tx_wr(tx_wr),
      .tx_wdata(tx_wdata), .rx_rd(rx_rd), .busy(busy), .frame_done(frame_done),
      .rx_word(rx_word), .start(start), .tx_word(tx_word), .rx_rdata(rx_rdata),
      .tx_empty(tx_empty), .rx_full(rx_full), .tx_irq(tx_irq), .rx_irq(rx_irq)
   );
endmodule

// File: rtl/dsm_checker.sv
module dsm_checker (
   input logic clk,
   input logic rst_n,
   input logic dbl_mode,
   input logic rx_rd,
   input logic busy,
   input logic start,
   input logic frame_done,
   input logic sclk,
   input logic tx_irq,
   input logic rx_irq,
   input logic tx_empty,
   input logic rx_full
);
   // R2
   idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sclk);

   // R3
   start_falls_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !sclk));

   // R9
   no_mid_frame_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !frame_done) |=> busy);

   // R10
   tx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |=> !tx_irq);

   // R10
   rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);

   // R10
   tx_irq_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> tx_irq);

   // R4
   single_end_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !dbl_mode) |=> (tx_empty && rx_full && rx_irq));

   // R11
   read_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full && rx_rd) |=> !rx_full);
endmodule

bind duplex_sync_master dsm_checker u_chk (
   .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .rx_rd(rx_rd), .busy(busy),
   .start(start), .frame_done(frame_done), .sclk(sclk), .tx_irq(tx_irq),
   .rx_irq(rx_irq), .tx_empty(tx_empty), .rx_full(rx_full)
);

// File: tb/sim_duplex_sync_master.sv
module sim_duplex_sync_master;
   localparam int DIV = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       dbl_mode = 1'b0;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_wdata = '0;
   logic       rx_rd = 1'b0;
   logic [7:0] rx_rdata;
   logic       tx_empty, rx_full, tx_irq, rx_irq, sclk, sdo;
   logic       sdi = 1'b0;

   duplex_sync_master #(.CLK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode), .tx_wr(tx_wr),
      .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
      .tx_empty(tx_empty), .rx_full(rx_full), .tx_irq(tx_irq), .rx_irq(rx_irq),
      .sclk(sclk), .sdo(sdo), .sdi(sdi)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   logic [7:0] slave_mem [512];
   logic [7:0] wq [512];
   logic [7:0] mon_tx [512];
   int nw = 0, nrd = 0, ntx = 0, nf = 0, nb = 0;
   int ntxirq = 0, nrxirq = 0;
   logic [7:0] mbyte = '0;
   time last_fall = 0;
   int lo_half = -1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit same(input int a, input int b);
      return a == b;
   endfunction

   // slave side: present next bit after each falling edge, LSB first
   always @(negedge sclk) if (rst_n) begin
      sdi <= slave_mem[(nf >> 3) % 512][nf % 8];
      nf++;
      last_fall = $time;
   end

   // capture master output on each rising edge
   always @(posedge sclk) if (rst_n && nf > 0) begin
      if (lo_half < 0) lo_half = int'(($time - last_fall) / 20);
      mbyte[nb % 8] = sdo;
      nb++;
      if (nb % 8 == 0) begin
         mon_tx[ntx % 512] = mbyte;
         ntx++;
      end
   end

   always @(negedge clk) if (rst_n) begin
      if (tx_irq) ntxirq++;
      if (rx_irq) nrxirq++;
   end

   task automatic cpu_write(input logic [7:0] d);
      @(negedge clk);
      if (tx_empty) begin
         wq[nw % 512] = d;
         nw++;
      end
      tx_wr = 1'b1;
      tx_wdata = d;
      @(negedge clk);
      tx_wr = 1'b0;
   endtask

   task automatic cpu_read();
      @(negedge clk);
      if (rx_full) begin
         // R11
         check(same(int'(rx_rdata), int'(slave_mem[nrd % 512])), "R11", "rx byte order",
               int'(rx_rdata), int'(slave_mem[nrd % 512]));
         nrd++;
      end
      rx_rd = 1'b1;
      @(negedge clk);
      rx_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_tx_irq(output bit rx_seen);
      int to = 0;
      do begin
         @(negedge clk);
         to++;
      end while (!tx_irq && to < 2000);
      rx_seen = rx_irq;
      check(tx_irq, "R10", "tx_irq arrived", int'(tx_irq), 1);
   endtask

   task automatic wait_nf(input int target);
      int to = 0;
      while (nf < target && to < 2000) begin
         @(negedge clk);
         to++;
      end
      #1;
   endtask

   task automatic random_phase(input int cycles);
      for (int i = 0; i < cycles; i++) begin
         int r;
         r = int'($urandom % 8);
         if (r < 2) cpu_write(8'($urandom));
         else if (r < 4) cpu_read();
         else idle(1);
      end
      for (int k = 0; k < 300; k++) cpu_read();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      bit rxs;
      int base;
      void'($urandom(32'd2718));
      for (int i = 0; i < 512; i++) slave_mem[i] = 8'($urandom);
      slave_mem[0] = 8'h96;
      slave_mem[1] = 8'h01;
      slave_mem[2] = 8'h80;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(sclk == 1'b1, "R1", "sclk after reset", int'(sclk), 1);
      check(sdo == 1'b1, "R1", "sdo after reset", int'(sdo), 1);
      check(tx_empty == 1'b1, "R1", "tx_empty after reset", int'(tx_empty), 1);
      check(rx_full == 1'b0, "R1", "rx_full after reset", int'(rx_full), 0);
      check(!tx_irq && !rx_irq, "R1", "irqs after reset", int'({tx_irq, rx_irq}), 0);

      // R2 clock stays idle without a write
      idle(20);
      check(nf == 0, "R2", "no clock before write", nf, 0);

      // R4 single mode frame
      cpu_write(8'hA5);
      wait_tx_irq(rxs);
      check(rxs, "R4", "rx_irq with tx_irq", int'(rxs), 1);
      @(negedge clk);
      check(tx_empty, "R4", "tx_empty at end", int'(tx_empty), 1);
      check(rx_full, "R4", "rx_full at end", int'(rx_full), 1);
      check(lo_half == DIV, "R3", "low phase length", lo_half, DIV);
      check(same(int'(mon_tx[0]), 8'hA5), "R3", "first byte on wire", int'(mon_tx[0]), 8'hA5);
      check(same(int'(rx_rdata), int'(slave_mem[0])), "R3", "first byte received",
            int'(rx_rdata), int'(slave_mem[0]));

      // R5 write first, then read
      cpu_write(8'h3C);
      idle(40);
      check(nf == 8, "R5", "stall until read", nf, 8);
      cpu_read();
      wait_tx_irq(rxs);
      check(same(int'(mon_tx[1]), 8'h3C), "R5", "byte after stall", int'(mon_tx[1]), 8'h3C);

      // R5 read first, then write
      idle(2);
      cpu_read();
      idle(40);
      check(nf == 16, "R5", "stall until write", nf, 16);
      cpu_write(8'h81);
      wait_tx_irq(rxs);
      check(same(int'(mon_tx[2]), 8'h81), "R5", "byte after late write", int'(mon_tx[2]), 8'h81);
      idle(2);
      cpu_read();

      // R6 write during a single-mode frame is ignored
      cpu_write(8'h11);
      idle(3);
      check(!tx_empty, "R6", "buffer held during frame", int'(tx_empty), 0);
      cpu_write(8'h99);
      wait_tx_irq(rxs);
      idle(40);
      check(nf == 32, "R6", "ignored write sends nothing", nf, 32);
      check(same(int'(mon_tx[3]), 8'h11), "R6", "original byte kept", int'(mon_tx[3]), 8'h11);
      cpu_read();

      // R7 / R8 double mode
      @(negedge clk);
      dbl_mode = 1'b1;
      base = nrxirq;
      cpu_write(8'h5A);
      idle(3);
      check(tx_empty, "R7", "tx_empty at frame start", int'(tx_empty), 1);
      cpu_write(8'hC3);
      wait_nf(41);
      check(tx_empty, "R7", "second byte moved back to back", int'(tx_empty), 1);
      cpu_write(8'h77);
      idle(120);
      check(nf == 48, "R8", "stall with hold occupied", nf, 48);
      check(rx_full && !tx_empty, "R8", "flags at stall", int'({rx_full, tx_empty}), 2);
      check(nrxirq - base == 1, "R8", "no rx_irq for held byte", nrxirq - base, 1);
      cpu_read();
      idle(3);
      check(rx_full, "R8", "held byte moved in", int'(rx_full), 1);
      check(nrxirq - base == 2, "R8", "rx_irq for drained byte", nrxirq - base, 2);
      check(nf > 48, "R8", "clock resumed", nf, 49);
      for (int k = 0; k < 120; k++) cpu_read();

      // random, double then single
      random_phase(2500);
      @(negedge clk);
      dbl_mode = 1'b0;
      random_phase(2500);

      // scoreboard
      idle(10);
      check(ntx == nw, "R6", "frames equal accepted writes", ntx, nw);
      for (int i = 0; i < ntx && i < 512; i++)
         check(same(int'(mon_tx[i]), int'(wq[i])), "R3", "wire byte order",
               int'(mon_tx[i]), int'(wq[i]));
      check(nrd == nf / 8, "R11", "all received bytes read", nrd, nf / 8);
      check(ntxirq == nf / 8, "R10", "one tx_irq per frame", ntxirq, nf / 8);
      check(nrxirq == nrd, "R10", "one rx_irq per byte", nrxirq, nrd);
      check(nf % 8 == 0 && sclk, "R9", "no partial frame", nf % 8, 0);

      summary();
      $finish;
   end
endmodule